// File: doc/BRIEF.md
# SDRAM Cache-Line Burst Sequencer

This block moves one 32-byte cache line between a cache and a synchronous DRAM with a 64-bit data path, as four 8-byte beats. A line is handled as two 16-byte halves, and each half gets its own column command with a two-beat burst. After a request is accepted, the block issues a row activate and then two column commands a fixed number of cycles apart. The second column command always carries auto precharge.

On a read fill, the half that holds the missed word goes first. Its first beat is the missed word itself, and the other beat of that half follows by wrapping around. The other half is then fetched from its lowest beat. Each returned beat is passed on with a one-cycle valid strobe and its beat index, so the cache can place the word.

On a write-back, the half holding the request address is written first, starting from that half's base, and the other half follows. A DMA acknowledge pulse leads the first data-write cycle. A configurable write-recovery wait comes after the write burst and ahead of the precharge wait. The block returns to ready only when every wait has elapsed.

Top module: `sdram_line_seq`

## Requirements
- R1: `ready` is high only while the block is idle, which includes the whole time after reset. A request is taken in a cycle where both `req_valid` and `ready` are high. The address, direction, write line and both configuration fields are captured in that cycle. `req_valid` and all request inputs are ignored while `ready` is low.
- R2: For a read accepted in cycle A, the command codes are as follows: `cmd` = 1 (activate) in cycle A+1, `cmd` = 2 (read) in cycle A+2, and `cmd` = 3 (read with auto precharge) in cycle A+2+COL_GAP. `cmd` = 0 (no operation) in every other cycle.
- R3: For a write accepted in cycle A, `cmd` = 1 in cycle A+2, `cmd` = 4 (write) in cycle A+3, and `cmd` = 5 (write with auto precharge) in cycle A+3+COL_GAP. `cmd` = 0 in every other cycle.
- R4: The address is split as follows: bits [4:3] select the start beat, bits [COL_W+2:5] are the upper column bits, the next BANK_W bits give `cmd_bank`, and the next ROW_W bits give `cmd_row`. For a read, `cmd_col` = {upper column bits, start beat} with the first command, and {upper column bits, !bit4, 0} with the second.
- R5: A read returns four beats. `rd_valid` is high for exactly one cycle per beat, in cycle C+CAS_LAT+1 and in cycle C+CAS_LAT+2 for each read command issued in cycle C. The beats arrive in the order b, b^1, {!b[1],0}, {!b[1],1}, where b is the start beat. `rd_beat` carries the beat index, and `rd_data` carries the `dram_rdata` value sampled CAS_LAT cycles after the beat's command slot.
- R6: On a write, `wr_en` is high in exactly four cycles: the two column-command cycles and the cycle after each. `wr_data` carries the line beats {h,0}, {h,1}, {!h,0}, {!h,1}, where h = bit 4 of the address. Beat k is `req_wdata[64k+63:64k]`.
- R7: For a write, `cmd_col` = {upper column bits, h, 0} with the first command and {upper column bits, !h, 0} with the second.
- R8: On a write, `dack` is high in exactly the two cycles just before the first write command. On a read, `dack` is never high.
- R9: After a write, `ready` returns in cycle W+2+RWL+RP+1. Here W is the cycle of the auto-precharge write, RWL is the captured `cfg_rwl` (0 to 7), and RP is the captured `cfg_rp` (0 to 3).
- R10: After a read, `ready` returns in cycle R+2+RP+1, where R is the cycle of the auto-precharge read. `cfg_rwl` has no effect on reads.
- R11: Address bits [2:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Line request present |
| req_write | input | 1 | 1 = write-back, 0 = read fill |
| req_addr | input | ADDR_W | Byte address of the line request |
| req_wdata | input | 4*64 | Write line, beat k in bits [64k+63:64k] |
| cfg_rwl | input | 3 | Write-recovery wait cycles |
| cfg_rp | input | 2 | Precharge wait minus one |
| ready | output | 1 | Idle and able to accept |
| cmd | output | 3 | Command code (0 nop, 1 act, 2 rd, 3 rd+ap, 4 wr, 5 wr+ap) |
| cmd_bank | output | BANK_W | Bank address |
| cmd_row | output | ROW_W | Row address, valid with activate |
| cmd_col | output | COL_W | Column address, valid with column commands |
| wr_en | output | 1 | Write data beat driven |
| wr_data | output | 64 | Write data beat |
| dack | output | 1 | DMA acknowledge |
| dram_rdata | input | 64 | Read data from the DRAM |
| rd_valid | output | 1 | Read beat strobe |
| rd_beat | output | 2 | Beat index of the read beat |
| rd_data | output | 64 | Read beat data |

## Verification
The assertions assume three things. COL_GAP is at least 2, so the two bursts never overlap. The DRAM returns read data exactly CAS_LAT cycles after each burst slot. `req_valid` is only acted on when `ready` is high, so command pairs and the acknowledge lead always come from one sequence at a time. The stimulus keeps within these limits: a response model returns beats at that fixed latency, and each new request starts only after `ready` is seen again. While a sequence is running, the stimulus sometimes holds junk requests and junk configuration on the inputs to show that they are ignored.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
    localparam int BEATS      = 4;
    localparam int HALF_BEATS = 2;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int WORD_W     = 64;
    localparam int LINE_W     = BEATS * WORD_W;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_RDAP = 3'd3,
        CMD_WR   = 3'd4,
        CMD_WRAP = 3'd5
    } sdl_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_DPRE = 4'd1,
        ST_ACT  = 4'd2,
        ST_COL1 = 4'd3,
        ST_GAP  = 4'd4,
        ST_COL2 = 4'd5,
        ST_TAIL = 4'd6,
        ST_RWL  = 4'd7,
        ST_RP   = 4'd8
    } sdl_state_e;
endpackage

// File: rtl/sdl_beat_order.sv
module sdl_beat_order
    import sdl_pkg::*;
(
    input  logic                         start_beat_0,
    input  logic                         start_beat_1,
    input  logic                         is_write,
    output logic [BEATS-1:0][BEAT_W-1:0] order
);
    logic              first_half;
    logic [BEAT_W-2:0] first_low;

    assign first_half = start_beat_1;
    // reads start at the critical beat, writes at the half's base
    assign first_low  = is_write ? '0 : (BEAT_W-1)'(start_beat_0);

    for (genvar k = 0; k < BEATS; k++) begin : g_slot
        localparam int   LOW    = k % HALF_BEATS;
        localparam logic SECOND = (k >= HALF_BEATS);
        logic [BEAT_W-2:0] low_k;
        if (k < HALF_BEATS) begin : g_first
            assign low_k = first_low + (BEAT_W-1)'(LOW);
        end else begin : g_second
            assign low_k = (BEAT_W-1)'(LOW);
        end
        assign order[k] = {first_half ^ SECOND, low_k};
    end

    always_comb begin
        logic [BEATS-1:0] seen;
        seen = '0;
        for (int k = 0; k < BEATS; k++) seen[order[k]] = 1'b1;
        // R5
        order_perm_chk: assert (&seen || $isunknown(order))
            else $error("beat order is not a permutation");
    end
endmodule

// File: rtl/sdl_rd_track.sv
module sdl_rd_track
    import sdl_pkg::*;
#(
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic [BEAT_W-1:0] in_beat,
    input  logic [WORD_W-1:0] dram_rdata,
    output logic              out_v,
    output logic [BEAT_W-1:0] out_beat,
    output logic [WORD_W-1:0] out_data
);
    typedef struct packed {
        logic              v;
        logic [BEAT_W-1:0] beat;
    } tag_t;

    typedef struct packed {
        tag_t [CAS_LAT-1:0] pipe;
        logic               v;
        logic [BEAT_W-1:0]  beat;
        logic [WORD_W-1:0]  data;
    } trk_t;

    trk_t trk_q, trk_d;

    always_comb begin
        trk_d = trk_q;
        trk_d.pipe[0].v    = in_v;
        trk_d.pipe[0].beat = in_beat;
        for (int i = 1; i < CAS_LAT; i++) trk_d.pipe[i] = trk_q.pipe[i-1];
        trk_d.v    = trk_q.pipe[CAS_LAT-1].v;
        trk_d.beat = trk_q.pipe[CAS_LAT-1].beat;
        trk_d.data = trk_q.pipe[CAS_LAT-1].v ? dram_rdata : trk_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign out_v    = trk_q.v;
    assign out_beat = trk_q.beat;
    assign out_data = trk_q.data;

    // R5
    rd_beat_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v && $past(out_v)) |-> (out_beat != $past(out_beat)))
        else $error("back-to-back read beats repeat an index");
endmodule

// File: rtl/sdram_line_seq.sv
module sdram_line_seq
    import sdl_pkg::*;
#(
    parameter int ROW_W   = 12,
    parameter int BANK_W  = 2,
    parameter int COL_W   = 8,
    parameter int CAS_LAT = 2,
    parameter int COL_GAP = 4,
    localparam int ADDR_W = 3 + COL_W + BANK_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    input  logic [2:0]        cfg_rwl,
    input  logic [1:0]        cfg_rp,
    output logic              ready,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              dack,
    input  logic [WORD_W-1:0] dram_rdata,
    output logic              rd_valid,
    output logic [BEAT_W-1:0] rd_beat,
    output logic [WORD_W-1:0] rd_data
);
    localparam int GAP_LOAD = COL_GAP - 2;
    localparam int CNT_W    = (GAP_LOAD > 7) ? $clog2(GAP_LOAD + 1) : 3;
    localparam int CB_W     = COL_W - BEAT_W;

    typedef struct packed {
        sdl_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              is_wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [CB_W-1:0]   colbase;
        logic [BEAT_W-1:0] beat0;
        logic [LINE_W-1:0] line;
        logic [2:0]        rwl;
        logic [1:0]        rp;
        sdl_cmd_e          cmd;
        logic [COL_W-1:0]  col;
        logic              xv;
        logic [BEAT_W-1:0] slot;
        logic              dack;
    } seq_t;

    seq_t seq_q, seq_d;
    logic [BEATS-1:0][BEAT_W-1:0] order;
    logic [2:0] addr_lo_unused;

    assign addr_lo_unused = req_addr[2:0];

    sdl_beat_order u_order (
        .start_beat_0 (seq_q.beat0[0]),
        .start_beat_1 (seq_q.beat0[1]),
        .is_write     (seq_q.is_wr),
        .order        (order)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.xv   = 1'b0;
        seq_d.cmd  = CMD_NOP;
        seq_d.dack = 1'b0;

        case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.is_wr   = req_write;
                    seq_d.beat0   = req_addr[4:3];
                    seq_d.colbase = req_addr[5 +: CB_W];
                    seq_d.bank    = req_addr[3 + COL_W +: BANK_W];
                    seq_d.row     = req_addr[3 + COL_W + BANK_W +: ROW_W];
                    seq_d.line    = req_wdata;
                    seq_d.rwl     = cfg_rwl;
                    seq_d.rp      = cfg_rp;
                    seq_d.state   = req_write ? ST_DPRE : ST_ACT;
                end
            end
            ST_DPRE: seq_d.state = ST_ACT;
            ST_ACT:  seq_d.state = ST_COL1;
            ST_COL1: begin
                seq_d.state = ST_GAP;
                seq_d.cnt   = CNT_W'(GAP_LOAD);
            end
            ST_GAP: begin
                if (seq_q.cnt == '0) seq_d.state = ST_COL2;
                else                 seq_d.cnt   = seq_q.cnt - CNT_W'(1);
            end
            ST_COL2: seq_d.state = ST_TAIL;
            ST_TAIL: begin
                if (seq_q.is_wr && seq_q.rwl != 3'd0) begin
                    seq_d.state = ST_RWL;
                    seq_d.cnt   = CNT_W'(seq_q.rwl - 3'd1);
                end else begin
                    seq_d.state = ST_RP;
                    seq_d.cnt   = CNT_W'(seq_q.rp);
                end
            end
            ST_RWL: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_RP;
                    seq_d.cnt   = CNT_W'(seq_q.rp);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            ST_RP: begin
                if (seq_q.cnt == '0) seq_d.state = ST_IDLE;
                else                 seq_d.cnt   = seq_q.cnt - CNT_W'(1);
            end
            default: seq_d.state = ST_IDLE;
        endcase

        // outputs registered alongside the state they belong to
        case (seq_d.state)
            ST_DPRE: seq_d.dack = 1'b1;
            ST_ACT: begin
                seq_d.cmd  = CMD_ACT;
                seq_d.dack = seq_d.is_wr;
            end
            ST_COL1: begin
                seq_d.cmd  = seq_d.is_wr ? CMD_WR : CMD_RD;
                seq_d.col  = {seq_d.colbase, order[0]};
                seq_d.xv   = 1'b1;
                seq_d.slot = BEAT_W'(0);
            end
            ST_COL2: begin
                seq_d.cmd  = seq_d.is_wr ? CMD_WRAP : CMD_RDAP;
                seq_d.col  = {seq_d.colbase, order[HALF_BEATS]};
                seq_d.xv   = 1'b1;
                seq_d.slot = BEAT_W'(HALF_BEATS);
            end
            default: ;
        endcase

        // second beat of each burst
        if (seq_q.state == ST_COL1) begin
            seq_d.xv   = 1'b1;
            seq_d.slot = BEAT_W'(1);
        end
        if (seq_q.state == ST_COL2) begin
            seq_d.xv   = 1'b1;
            seq_d.slot = BEAT_W'(HALF_BEATS + 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ready    = (seq_q.state == ST_IDLE);
    assign cmd      = seq_q.cmd;
    assign cmd_bank = seq_q.bank;
    assign cmd_row  = seq_q.row;
    assign cmd_col  = seq_q.col;
    assign dack     = seq_q.dack;
    assign wr_en    = seq_q.xv & seq_q.is_wr;
    assign wr_data  = seq_q.line[order[seq_q.slot] * WORD_W +: WORD_W];

    sdl_rd_track #(.CAS_LAT(CAS_LAT)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_v       (seq_q.xv & ~seq_q.is_wr),
        .in_beat    (order[seq_q.slot]),
        .dram_rdata (dram_rdata),
        .out_v      (rd_valid),
        .out_beat   (rd_beat),
        .out_data   (rd_data)
    );

    // cycle counter since the first column command, for the spacing check
    int unsigned gap_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 gap_seen_q <= 0;
        else if (cmd == CMD_RD || cmd == CMD_WR)    gap_seen_q <= 1;
        else if (gap_seen_q != 0 && gap_seen_q < 32'd100000) gap_seen_q <= gap_seen_q + 1;
    end

    // R2
    col_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RDAP || cmd == CMD_WRAP) |-> (gap_seen_q == COL_GAP))
        else $error("second column command off its slot");

    // R8
    dack_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |-> ($past(dack) && $past(dack, 2)))
        else $error("acknowledge did not lead the write");

    // R8
    dack_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD) |-> (!$past(dack) && !dack))
        else $error("acknowledge seen on a read");

    // R1
    act_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && !dack) |-> $past(ready && req_valid))
        else $error("read activate without an accepted request");

    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || cmd != CMD_NOP) |-> !ready)
        else $error("ready while a sequence is active");
endmodule

// File: tb/tb_sdram_line_seq.sv
module tb_sdram_line_seq;
    localparam int ROW_W = 12, BANK_W = 2, COL_W = 8, CL = 2, G = 4;
    localparam int ADDR_W = 3 + COL_W + BANK_W + ROW_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [255:0] req_wdata = '0;
    logic [2:0] cfg_rwl = '0;
    logic [1:0] cfg_rp = '0;
    logic ready, wr_en, dack, rd_valid;
    logic [2:0] cmd;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic [63:0] wr_data, rd_data;
    logic [63:0] dram_rdata = '0;
    logic [1:0] rd_beat;

    int n_chk = 0, n_bad = 0;
    int errs [6];
    logic [63:0] fa [6], fe [6];
    logic [63:0] mq [CL+2];

    always #5 clk = ~clk;

    sdram_line_seq #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
                     .CAS_LAT(CL), .COL_GAP(G)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_rwl(cfg_rwl), .cfg_rp(cfg_rp),
        .ready(ready), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .wr_en(wr_en), .wr_data(wr_data), .dack(dack),
        .dram_rdata(dram_rdata), .rd_valid(rd_valid), .rd_beat(rd_beat), .rd_data(rd_data));

    function automatic logic [63:0] pat(input logic [BANK_W-1:0] b,
                                        input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
        return {32'hC0DE0000 ^ 32'(r), 16'(b) ^ 16'h3C00, 16'(c) ^ 16'h0A50};
    endfunction

    // expected beat for slot k
    function automatic logic [1:0] exp_beat(input logic [1:0] b, input bit wr, input int k);
        logic lo;
        if (k < 2) begin
            lo = wr ? 1'(k) : (b[0] ^ 1'(k));
            return {b[1], lo};
        end
        return {~b[1], 1'(k - 2)};
    endfunction

    // DRAM read response model
    always @(negedge clk) begin
        for (int i = 0; i <= CL; i++) mq[i] = mq[i+1];
        mq[CL+1] = '0;
        dram_rdata = mq[0];
        if (cmd == 3'd2 || cmd == 3'd3) begin
            mq[CL]   = pat(cmd_bank, cmd_row, cmd_col);
            mq[CL+1] = pat(cmd_bank, cmd_row, cmd_col ^ 1);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic note(input int g, input logic [63:0] act, input logic [63:0] exp);
        if (errs[g] == 0) begin fa[g] = act; fe[g] = exp; end
        errs[g]++;
    endtask

    task automatic run_txn(input bit wr, input logic [ADDR_W-1:0] a, input logic [2:0] rwl,
                           input logic [1:0] rp, input bit junk, input bit lowtest);
        logic [1:0] b;
        logic [COL_W-3:0] cb;
        logic [BANK_W-1:0] bk;
        logic [ROW_W-1:0] rw;
        logic [255:0] line;
        int c1, c2, rdy, last, total;
        b  = a[4:3];
        cb = a[COL_W+2:5];
        bk = a[3+COL_W +: BANK_W];
        rw = a[3+COL_W+BANK_W +: ROW_W];
        for (int i = 0; i < 8; i++) line[32*i +: 32] = $urandom;
        for (int g = 0; g < 6; g++) errs[g] = 0;
        c1 = wr ? 3 : 2;
        c2 = c1 + G;
        rdy = c2 + 2 + (wr ? int'(rwl) : 0) + int'(rp) + 1;
        last = (rdy > c2 + CL + 2) ? rdy : c2 + CL + 2;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = line;
        cfg_rwl = rwl; cfg_rp = rp;
        for (int rel = 1; rel <= last; rel++) begin
            logic [2:0] ec;
            bit ew, ed, er;
            int k;
            @(negedge clk);
            if (rel == 1) begin
                req_valid = junk; req_write = $urandom; req_addr = ADDR_W'($urandom);
                req_wdata = ~line; cfg_rwl = 3'($urandom); cfg_rp = 2'($urandom);
            end
            ec = (rel == c1 - 1) ? 3'd1 : (rel == c1) ? (wr ? 3'd4 : 3'd2) :
                 (rel == c2) ? (wr ? 3'd5 : 3'd3) : 3'd0;
            if (cmd != ec) note(0, 64'(cmd), 64'(ec));
            if (ec == 3'd1 && (cmd_bank != bk || cmd_row != rw))
                note(1, {cmd_bank, cmd_row}, {bk, rw});
            if (ec == 3'd2 || ec == 3'd4)
                if (cmd_col != {cb, exp_beat(b, wr, 0)}) note(1, 64'(cmd_col), 64'({cb, exp_beat(b, wr, 0)}));
            if (ec == 3'd3 || ec == 3'd5)
                if (cmd_col != {cb, exp_beat(b, wr, 2)}) note(1, 64'(cmd_col), 64'({cb, exp_beat(b, wr, 2)}));
            k = (rel == c1) ? 0 : (rel == c1 + 1) ? 1 : (rel == c2) ? 2 : (rel == c2 + 1) ? 3 : -1;
            ew = wr && k >= 0;
            if (wr_en != ew) note(2, 64'(wr_en), 64'(ew));
            else if (ew && wr_data != line[64*exp_beat(b, wr, k) +: 64])
                note(2, wr_data, line[64*exp_beat(b, wr, k) +: 64]);
            ed = wr && (rel == c1 - 1 || rel == c1 - 2);
            if (dack != ed) note(3, 64'(dack), 64'(ed));
            k = (rel == c1 + CL + 1) ? 0 : (rel == c1 + CL + 2) ? 1 :
                (rel == c2 + CL + 1) ? 2 : (rel == c2 + CL + 2) ? 3 : -1;
            er = !wr && k >= 0;
            if (rd_valid != er) note(4, 64'(rd_valid), 64'(er));
            else if (er && rd_beat != exp_beat(b, 1'b0, k)) note(4, 64'(rd_beat), 64'(exp_beat(b, 1'b0, k)));
            else if (er && rd_data != pat(bk, rw, {cb, exp_beat(b, 1'b0, k)}))
                note(4, rd_data, pat(bk, rw, {cb, exp_beat(b, 1'b0, k)}));
            if (ready != (rel >= rdy)) note(5, 64'(ready), 64'(rel >= rdy));
            if (rel == rdy) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        total = errs[0] + errs[1] + errs[2] + errs[3] + errs[4] + errs[5];
        if (lowtest) chk(total == 0, "R11 low address bits change an output", 64'(total), 64'd0);
        if (wr) begin
            chk(errs[0] == 0, "R3 write command cycles", fa[0], fe[0]);
            chk(errs[1] == 0, "R7 write bank/row/column", fa[1], fe[1]);
            chk(errs[2] == 0, "R6 write data beats", fa[2], fe[2]);
            chk(errs[3] == 0, "R8 acknowledge lead on write", fa[3], fe[3]);
            chk(errs[5] == 0, "R9 write recovery ready timing", fa[5], fe[5]);
        end else begin
            chk(errs[0] == 0, "R2 read command cycles", fa[0], fe[0]);
            chk(errs[1] == 0, "R4 read bank/row/column", fa[1], fe[1]);
            chk(errs[4] == 0, "R5 read beat delivery", fa[4], fe[4]);
            chk(errs[3] == 0, "R8 no acknowledge on read", fa[3], fe[3]);
            chk(errs[5] == 0, "R10 read precharge ready timing", fa[5], fe[5]);
        end
        if (junk) chk(errs[0] + errs[2] == 0, "R1 busy request ignored", 64'(errs[0]), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < CL + 2; i++) mq[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready && cmd == 3'd0 && !dack && !wr_en && !rd_valid, "R1 reset state",
            {59'd0, ready, cmd == 3'd0, dack, wr_en, rd_valid}, 64'h18);
        for (int bt = 0; bt < 4; bt++) begin
            for (int w = 0; w < 2; w++) begin
                logic [ADDR_W-1:0] a;
                a = ADDR_W'($urandom);
                a[4:3] = 2'(bt);
                a[2:0] = 3'd0;
                run_txn(w[0], a, (bt[0] ? 3'd7 : 3'd0), (bt[1] ? 2'd3 : 2'd0), w[0] ^ bt[0], 1'b0);
            end
        end
        for (int w = 0; w < 2; w++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom);
            a[2:0] = 3'd7;
            run_txn(w[0], a, 3'd2, 2'd1, 1'b0, 1'b1);
        end
        for (int n = 0; n < 40; n++)
            run_txn(1'($urandom), ADDR_W'($urandom), 3'($urandom), 2'($urandom),
                    1'($urandom), 1'b0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule